// File: doc/BRIEF.md
# Multidrop Address-Wake Serial Framer

This block adds address/data tagging to one asynchronous serial channel, in both directions. On the transmit side each character carries one extra tag bit between its data bits and its stop bits. The tag marks the character as an address (1) or as data (0). On the receive side the tag of every incoming character is decoded, and a filter decides whether the character goes on to the receive FIFO.

Software normally leaves a listening station's receiver disabled. The station then sees only address characters: each one raises a ready event, and the stored character carries its tag in the status slot that parity error uses in other modes. Once software has matched its own station address, it enables the receiver. From then on every character goes through, whatever its tag, until software decides to disable it again.

Bit timing comes from an oversampling tick supplied from outside. The FIFO and the bus interface sit outside the block: it produces write strobes with data and status, and it takes a full indication back.

Top module: `mdw_uart`

## Requirements
- R1: Multidrop operation applies only when the 2-bit parity-mode input `mode_pm` equals 2'b11. With any other value, frames carry no tag bit, status bit 5 is written as 0, and a disabled receiver stores no character at all.
- R2: A transmitted frame is, in time order: one low start bit, then N data bits least significant first, where N = 5 + `mode_len` (00 gives 5, 11 gives 8), then the tag bit in multidrop only, then one high stop bit (`mode_two_stop`=0) or two (=1). Each bit lasts OVERSAMPLE pulses of `os_tick`.
- R3: The tag bit sent equals `mode_tag` as sampled in the cycle the character is loaded. A later change to `mode_tag` does not alter that frame, and a `tx_load` pulse while `tx_busy` is high is ignored.
- R4: In multidrop, a disabled receiver (`rx_en`=0) writes a received character to the FIFO only when its tag is 1. A character tagged 0 produces no `fifo_wr`.
- R5: An enabled receiver writes every received character, whatever its tag. Data bits above N are written as 0.
- R6: The status byte written with each character is {bit7 break, bit6 framing error, bit5 received tag, bit4 overrun, bits3:0 zero}. A framing error means the first stop bit was sampled low. A break means the data bits, the tag and the stop bit were all low. Both flags are reported whether the receiver is enabled or disabled.
- R7: A character that passes the filter while `fifo_full` is high is not written. The next character that is written carries status bit 4 set, and bit 4 is clear again on the write after that.
- R8: `rx_rdy_set` pulses for exactly the cycles in which `fifo_wr` is high.
- R9: After a character whose stop bit was sampled low, the receiver looks for a new start bit only once the line has been seen high.
- R10: During and after reset, with no frame in progress, `tx_line` is high, `tx_busy` is low and `fifo_wr` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| os_tick | input | 1 | Oversampling tick; OVERSAMPLE ticks form one bit time |
| mode_pm | input | 2 | Parity-mode field; 2'b11 selects multidrop |
| mode_tag | input | 1 | Tag value for the next transmitted character (1 = address) |
| mode_len | input | 2 | Data bits per character minus 5 |
| mode_two_stop | input | 1 | 1 selects two transmitted stop bits |
| rx_en | input | 1 | Receiver enable |
| rx_line | input | 1 | Serial receive line |
| tx_load | input | 1 | Load `tx_data` into the transmitter when idle |
| tx_data | input | 8 | Character to transmit |
| fifo_full | input | 1 | Receive FIFO cannot take a write |
| tx_line | output | 1 | Serial transmit line |
| tx_busy | output | 1 | A frame is being sent |
| fifo_wr | output | 1 | Receive FIFO write strobe |
| fifo_data | output | 8 | Received data bits |
| fifo_stat | output | 8 | Per-character status written with the data |
| rx_rdy_set | output | 1 | Ready event for the received-character flag |

## Verification
The bench aims at the filter's split between tags. An address character sent to a disabled receiver must reach the FIFO, and a data character must vanish. A design that reversed the test, or that ignored the enable, would show up as a missing or unexpected write. It changes `mode_tag` in the middle of a frame and pulses `tx_load` while busy. A design that read the tag live, or that restarted on a second load, would put the wrong bit on the line or write an extra character. Break and framing-error frames are sent with the receiver disabled and with it enabled. The line is then held low after a break, where a receiver that restarted at once would produce a second break character. An overrun is forced with `fifo_full`, to show that the lost character is flagged on exactly the next write.

// File: rtl/mdw_pkg.sv
package mdw_pkg;

  localparam int MAX_DATA = 8;
  // start + data + tag + two stops
  localparam int FRAME_W  = 1 + MAX_DATA + 1 + 2;
  // data + tag + first stop on the receive side
  localparam int RXBITS_W = MAX_DATA + 2;

  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_BITS, RX_HOLD} rx_state_e;

  typedef struct packed {
    logic       brk;
    logic       ferr;
    logic       tag;
    logic       ovr;
    logic [3:0] zero;
  } rx_stat_t;

  function automatic int data_bits(input logic [1:0] len);
    return 5 + int'(len);
  endfunction

  function automatic logic is_multidrop(input logic [1:0] pm);
    return pm == 2'b11;
  endfunction

  // total bit times of one transmitted frame
  function automatic logic [3:0] frame_bits(input logic [1:0] len, input logic md,
                                            input logic two_stop);
    return 4'd1 + 4'(data_bits(len)) + {3'b000, md} + 4'd1 + {3'b000, two_stop};
  endfunction

  // serial image of one frame, bit 0 goes out first; unused tail stays high
  function automatic logic [FRAME_W-1:0] build_frame(input logic [7:0] data,
                                                     input logic [1:0] len,
                                                     input logic md, input logic tag);
    logic [FRAME_W-1:0] f;
    int n;
    n = data_bits(len);
    f = '1;
    f[0] = 1'b0;
    for (int i = 0; i < MAX_DATA; i++) begin
      if (i < n) f[i+1] = data[i];
    end
    if (md) f[n+1] = tag;
    return f;
  endfunction

  function automatic logic [7:0] mask_data(input logic [RXBITS_W-1:0] bits,
                                           input logic [1:0] len);
    logic [7:0] d;
    int n;
    n = data_bits(len);
    for (int i = 0; i < MAX_DATA; i++) begin
      d[i] = (i < n) ? bits[i] : 1'b0;
    end
    return d;
  endfunction

endpackage

// File: rtl/mdw_tx.sv
module mdw_tx
  import mdw_pkg::*;
#(
  parameter int OVERSAMPLE = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       os_tick,
  input  logic       tx_load,
  input  logic [7:0] tx_data,
  input  logic [1:0] len,
  input  logic       md,
  input  logic       tag,
  input  logic       two_stop,
  output logic       tx_busy,
  output logic       tx_line,
  output logic       bit_step
);

  localparam int CNT_W = (OVERSAMPLE > 2) ? $clog2(OVERSAMPLE) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(OVERSAMPLE - 1);

  logic [FRAME_W-1:0] sh_q;
  logic [3:0]         left_q;
  logic [CNT_W-1:0]   div_q;
  logic               busy_q;

  assign bit_step = busy_q && os_tick && (div_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '1;
      left_q <= '0;
      div_q  <= '0;
      busy_q <= 1'b0;
    end else if (!busy_q) begin
      if (tx_load) begin
        // mode and tag are frozen into the shift image here
        sh_q   <= build_frame(tx_data, len, md, tag);
        left_q <= frame_bits(len, md, two_stop);
        div_q  <= '0;
        busy_q <= 1'b1;
      end
    end else if (os_tick) begin
      if (div_q == LAST) begin
        div_q  <= '0;
        sh_q   <= {1'b1, sh_q[FRAME_W-1:1]};
        left_q <= left_q - 4'd1;
        if (left_q == 4'd1) busy_q <= 1'b0;
      end else begin
        div_q <= div_q + 1'b1;
      end
    end
  end

  assign tx_busy = busy_q;
  assign tx_line = busy_q ? sh_q[0] : 1'b1;

endmodule

// File: rtl/mdw_rx.sv
module mdw_rx
  import mdw_pkg::*;
#(
  parameter int OVERSAMPLE  = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       os_tick,
  input  logic       rx_line,
  input  logic [1:0] len,
  input  logic       md,
  output logic       char_done,
  output logic [7:0] char_data,
  output logic       char_tag,
  output logic       char_md,
  output logic       char_ferr,
  output logic       char_brk
);

  localparam int CNT_W = (OVERSAMPLE > 2) ? $clog2(OVERSAMPLE) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(OVERSAMPLE - 1);
  localparam logic [CNT_W-1:0] HALF = CNT_W'(OVERSAMPLE / 2 - 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   line_s;

  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= rx_line;
      end
    end else begin : g_syncn
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], rx_line};
      end
    end
  endgenerate
  assign line_s = sync_q[SYNC_STAGES-1];

  rx_state_e             state_q;
  logic [CNT_W-1:0]      div_q;
  logic [3:0]            idx_q;
  logic [3:0]            last_q;
  logic [RXBITS_W-1:0]   bits_q;
  logic [1:0]            len_q;
  logic                  md_q;

  // sampled bits including the one taken this cycle
  logic [RXBITS_W-1:0]   bits_now;
  logic [7:0]            data_now;
  logic                  tag_now;
  logic                  brk_now;
  logic                  sample_now;
  logic                  last_now;

  always_comb begin
    bits_now = bits_q;
    for (int i = 0; i < RXBITS_W; i++) begin
      if (idx_q == 4'(i)) bits_now[i] = line_s;
    end
  end

  assign data_now   = mask_data(bits_now, len_q);
  assign tag_now    = md_q & bits_now[data_bits(len_q)];
  assign brk_now    = (data_now == 8'h00) && !tag_now && !line_s;
  assign sample_now = (state_q == RX_BITS) && os_tick && (div_q == LAST);
  assign last_now   = sample_now && (idx_q == last_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= RX_IDLE;
      div_q     <= '0;
      idx_q     <= '0;
      last_q    <= '0;
      bits_q    <= '0;
      len_q     <= '0;
      md_q      <= 1'b0;
      char_done <= 1'b0;
      char_data <= '0;
      char_tag  <= 1'b0;
      char_md   <= 1'b0;
      char_ferr <= 1'b0;
      char_brk  <= 1'b0;
    end else begin
      char_done <= 1'b0;
      case (state_q)
        RX_IDLE: begin
          if (os_tick && !line_s) begin
            state_q <= RX_START;
            div_q   <= '0;
          end
        end
        RX_START: begin
          if (os_tick) begin
            if (div_q == HALF) begin
              div_q <= '0;
              if (!line_s) begin
                state_q <= RX_BITS;
                idx_q   <= '0;
                len_q   <= len;
                md_q    <= md;
                last_q  <= 4'(data_bits(len)) + {3'b000, md};
              end else begin
                state_q <= RX_IDLE;
              end
            end else begin
              div_q <= div_q + 1'b1;
            end
          end
        end
        RX_BITS: begin
          if (os_tick) begin
            if (div_q == LAST) begin
              div_q  <= '0;
              bits_q <= bits_now;
              idx_q  <= idx_q + 4'd1;
            end else begin
              div_q <= div_q + 1'b1;
            end
          end
          if (last_now) begin
            char_done <= 1'b1;
            char_data <= data_now;
            char_tag  <= tag_now;
            char_md   <= md_q;
            char_ferr <= !line_s;
            char_brk  <= brk_now;
            state_q   <= line_s ? RX_IDLE : RX_HOLD;
          end
        end
        default: begin
          // low stop bit: wait for the line to come back high
          if (line_s) state_q <= RX_IDLE;
        end
      endcase
    end
  end

endmodule

// File: rtl/mdw_filter.sv
module mdw_filter
  import mdw_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       char_done,
  input  logic [7:0] char_data,
  input  logic       char_tag,
  input  logic       char_md,
  input  logic       char_ferr,
  input  logic       char_brk,
  input  logic       rx_en,
  input  logic       fifo_full,
  output logic       accept,
  output logic       fifo_wr,
  output logic [7:0] fifo_data,
  output logic [7:0] fifo_stat
);

  logic     ovr_q;
  logic     lost;
  rx_stat_t stat;

  // disabled receivers in multidrop still take address characters
  assign accept  = char_done && (rx_en || (char_md && char_tag));
  assign fifo_wr = accept && !fifo_full;
  assign lost    = accept && fifo_full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ovr_q <= 1'b0;
    else if (fifo_wr) ovr_q <= 1'b0;
    else if (lost)    ovr_q <= 1'b1;
  end

  always_comb begin
    stat.brk  = char_brk;
    stat.ferr = char_ferr;
    stat.tag  = char_md & char_tag;
    stat.ovr  = ovr_q;
    stat.zero = 4'h0;
  end

  assign fifo_stat = stat;
  assign fifo_data = char_data;

endmodule

// File: rtl/mdw_uart.sv
module mdw_uart
  import mdw_pkg::*;
#(
  parameter int OVERSAMPLE  = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       os_tick,
  input  logic [1:0] mode_pm,
  input  logic       mode_tag,
  input  logic [1:0] mode_len,
  input  logic       mode_two_stop,
  input  logic       rx_en,
  input  logic       rx_line,
  input  logic       tx_load,
  input  logic [7:0] tx_data,
  input  logic       fifo_full,
  output logic       tx_line,
  output logic       tx_busy,
  output logic       fifo_wr,
  output logic [7:0] fifo_data,
  output logic [7:0] fifo_stat,
  output logic       rx_rdy_set
);

  logic       md;
  logic       tx_bit_step;
  logic       char_done;
  logic [7:0] char_data;
  logic       char_tag;
  logic       char_md;
  logic       char_ferr;
  logic       char_brk;
  logic       char_accept;

  assign md = is_multidrop(mode_pm);

  mdw_tx #(.OVERSAMPLE(OVERSAMPLE)) tx_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .os_tick  (os_tick),
    .tx_load  (tx_load),
    .tx_data  (tx_data),
    .len      (mode_len),
    .md       (md),
    .tag      (mode_tag),
    .two_stop (mode_two_stop),
    .tx_busy  (tx_busy),
    .tx_line  (tx_line),
    .bit_step (tx_bit_step)
  );

  mdw_rx #(.OVERSAMPLE(OVERSAMPLE), .SYNC_STAGES(SYNC_STAGES)) rx_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .os_tick   (os_tick),
    .rx_line   (rx_line),
    .len       (mode_len),
    .md        (md),
    .char_done (char_done),
    .char_data (char_data),
    .char_tag  (char_tag),
    .char_md   (char_md),
    .char_ferr (char_ferr),
    .char_brk  (char_brk)
  );

  mdw_filter filt_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .char_done (char_done),
    .char_data (char_data),
    .char_tag  (char_tag),
    .char_md   (char_md),
    .char_ferr (char_ferr),
    .char_brk  (char_brk),
    .rx_en     (rx_en),
    .fifo_full (fifo_full),
    .accept    (char_accept),
    .fifo_wr   (fifo_wr),
    .fifo_data (fifo_data),
    .fifo_stat (fifo_stat)
  );

  assign rx_rdy_set = fifo_wr;

endmodule

// File: rtl/mdw_uart_chk.sv
module mdw_uart_chk (
  input logic clk,
  input logic rst_n,
  input logic tx_busy,
  input logic tx_line,
  input logic tx_bit_step,
  input logic fifo_wr,
  input logic fifo_full,
  input logic rx_rdy_set,
  input logic rx_en,
  input logic char_done,
  input logic char_md,
  input logic char_tag,
  input logic stat_tag
);

  p_idle_high_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_busy |-> tx_line);

  p_start_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_busy) |-> !tx_line);

  p_end_on_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_busy) |-> $past(tx_bit_step));

  p_rdy_with_wr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_rdy_set == fifo_wr);

  p_no_wr_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_full |-> !fifo_wr);

  p_drop_data_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (char_done && char_md && !rx_en && !char_tag) |-> !fifo_wr);

  p_pass_all_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (char_done && rx_en && !fifo_full) |-> fifo_wr);

  p_plain_tag_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_wr && !char_md) |-> !stat_tag);

  p_wr_needs_char_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_wr |-> char_done);

endmodule

bind mdw_uart mdw_uart_chk chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .tx_busy     (tx_busy),
  .tx_line     (tx_line),
  .tx_bit_step (tx_bit_step),
  .fifo_wr     (fifo_wr),
  .fifo_full   (fifo_full),
  .rx_rdy_set  (rx_rdy_set),
  .rx_en       (rx_en),
  .char_done   (char_done),
  .char_md     (char_md),
  .char_tag    (char_tag),
  .stat_tag    (fifo_stat[5])
);

// File: tb/mdw_uart_tb_top.sv
module mdw_uart_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int OS = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       os_tick = 1'b1;
  logic [1:0] mode_pm = 2'b00;
  logic       mode_tag = 1'b0;
  logic [1:0] mode_len = 2'b11;
  logic       mode_two_stop = 1'b0;
  logic       rx_en = 1'b0;
  logic       tx_load = 1'b0;
  logic [7:0] tx_data = 8'h00;
  logic       fifo_full = 1'b0;
  logic       loop = 1'b1;
  logic       raw_line = 1'b1;
  logic       rx_line;
  logic       tx_line, tx_busy, fifo_wr, rx_rdy_set;
  logic [7:0] fifo_data, fifo_stat;

  int  checks = 0;
  int  bad = 0;
  bit  ended = 1'b0;
  bit  ovr_m = 1'b0;

  logic [15:0] exp_q[$];
  string       req_q[$];

  assign rx_line = loop ? tx_line : raw_line;

  always #(CLK_PERIOD/2) clk = ~clk;

  mdw_uart #(.OVERSAMPLE(OS)) dut_i (
    .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .mode_pm(mode_pm),
    .mode_tag(mode_tag), .mode_len(mode_len), .mode_two_stop(mode_two_stop),
    .rx_en(rx_en), .rx_line(rx_line), .tx_load(tx_load), .tx_data(tx_data),
    .fifo_full(fifo_full), .tx_line(tx_line), .tx_busy(tx_busy),
    .fifo_wr(fifo_wr), .fifo_data(fifo_data), .fifo_stat(fifo_stat),
    .rx_rdy_set(rx_rdy_set)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  endtask

  // model of the filter and status, written from the requirements
  task automatic expect_char(input logic [7:0] d, input logic [1:0] len, input bit md,
                             input bit tag, input bit ferr, input bit brk, input bit en,
                             input bit full, input string req);
    logic [7:0] dm;
    logic [7:0] st;
    dm = 8'h00;
    for (int i = 0; i < 5 + int'(len); i++) dm[i] = d[i];
    if (en || (md && tag)) begin
      if (full) ovr_m = 1'b1;
      else begin
        st = {brk, ferr, md & tag, ovr_m, 4'h0};
        exp_q.push_back({st, dm});
        req_q.push_back(req);
        ovr_m = 1'b0;
      end
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && fifo_wr) begin
      check("R8 ready event with write", {15'h0, rx_rdy_set}, 16'h0001);
      if (exp_q.size() == 0) begin
        checks++;
        bad++;
        $display("FAIL R4 unexpected write: actual=%h expected=none", {fifo_stat, fifo_data});
      end else begin
        logic [15:0] e;
        string r;
        e = exp_q.pop_front();
        r = req_q.pop_front();
        check(r, {fifo_stat, fifo_data}, e);
      end
    end
  end

  // loopback transmit: checks every bit on the line and queues the receive result
  task automatic send_tx(input logic [7:0] d, input logic [1:0] len, input bit md,
                         input bit tag, input bit two, input bit en, input bit flip,
                         input bit extra, input bit full, input string req);
    logic eb [0:11];
    int   nb;
    nb = 0;
    eb[nb] = 1'b0; nb++;
    for (int i = 0; i < 5 + int'(len); i++) begin eb[nb] = d[i]; nb++; end
    if (md) begin eb[nb] = tag; nb++; end
    eb[nb] = 1'b1; nb++;
    if (two) begin eb[nb] = 1'b1; nb++; end
    @(negedge clk);
    loop = 1'b1;
    mode_pm = md ? 2'b11 : 2'b00;
    mode_tag = tag;
    mode_len = len;
    mode_two_stop = two;
    rx_en = en;
    fifo_full = full;
    expect_char(d, len, md, tag, 1'b0, 1'b0, en, full, req);
    tx_data = d;
    tx_load = 1'b1;
    @(negedge clk);
    tx_load = 1'b0;
    repeat (OS/2) @(negedge clk);
    for (int k = 0; k < nb; k++) begin
      check($sformatf("%s bit %0d", req, k), {15'h0, tx_line}, {15'h0, eb[k]});
      if (k < nb - 1) begin
        for (int j = 0; j < OS; j++) begin
          @(negedge clk);
          tx_load = 1'b0;
          if (flip && k == 0 && j == 0) mode_tag = ~mode_tag;
          if (extra && k == 1 && j == 0) begin
            tx_data = ~d;
            tx_load = 1'b1;
          end
        end
      end
    end
    tx_load = 1'b0;
    for (int w = 0; w < 4 * OS && tx_busy; w++) @(negedge clk);
    repeat (2 * OS) @(negedge clk);
    check({req, " idle after frame"}, {14'h0, tx_busy, tx_line}, 16'h0001);
    fifo_full = 1'b0;
  endtask

  // bench-driven receive frame with chosen stop value
  task automatic send_raw(input logic [7:0] d, input logic [1:0] len, input bit md,
                          input bit tag, input bit stopv, input bit en, input int hold_low,
                          input string req);
    logic [7:0] dm;
    bit brk;
    dm = 8'h00;
    for (int i = 0; i < 5 + int'(len); i++) dm[i] = d[i];
    brk = !stopv && (dm == 8'h00) && !(md && tag);
    @(negedge clk);
    loop = 1'b0;
    raw_line = 1'b1;
    mode_pm = md ? 2'b11 : 2'b00;
    mode_len = len;
    rx_en = en;
    expect_char(d, len, md, tag, !stopv, brk, en, 1'b0, req);
    raw_line = 1'b0;
    repeat (OS) @(negedge clk);
    for (int i = 0; i < 5 + int'(len); i++) begin
      raw_line = d[i];
      repeat (OS) @(negedge clk);
    end
    if (md) begin
      raw_line = tag;
      repeat (OS) @(negedge clk);
    end
    raw_line = stopv;
    repeat (OS) @(negedge clk);
    repeat (hold_low) @(negedge clk);
    raw_line = 1'b1;
    repeat (3 * OS) @(negedge clk);
    loop = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    check("R10 reset tx_line/tx_busy/fifo_wr", {13'h0, tx_line, tx_busy, fifo_wr}, 16'h0004);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R10 idle after reset", {14'h0, tx_line, tx_busy}, 16'h0002);

    // R2/R4: address character reaches a disabled receiver
    send_tx(8'hA5, 2'b11, 1, 1, 0, 0, 0, 0, 0, "R4 address while disabled");
    // R4: data character is dropped by a disabled receiver
    send_tx(8'h3C, 2'b11, 1, 0, 0, 0, 0, 0, 0, "R4 data dropped");
    // R5: enabled, tag 0, 7 bits, two stops
    send_tx(8'hDA, 2'b10, 1, 0, 1, 1, 0, 0, 0, "R5 enabled data 7b");
    // R1: plain mode, 5 bits, no tag bit
    send_tx(8'h1F, 2'b00, 0, 1, 0, 1, 0, 0, 0, "R1 plain 5b");
    // R1: plain mode with receiver disabled stores nothing
    send_tx(8'h77, 2'b01, 0, 1, 0, 0, 0, 0, 0, "R1 plain disabled");
    // R3: tag changed mid-frame keeps the loaded value
    send_tx(8'hC3, 2'b11, 1, 1, 0, 1, 1, 0, 0, "R3 tag sampled at load");
    // R3: load while busy ignored
    send_tx(8'h96, 2'b11, 1, 0, 0, 1, 0, 1, 0, "R3 load while busy");
    // R6: framing error on an address character while disabled
    send_raw(8'h42, 2'b11, 1, 1, 0, 0, 0, "R6 framing while disabled");
    // R6/R9: break held low, then a normal character
    send_raw(8'h00, 2'b11, 1, 0, 0, 1, 4 * OS, "R6 break enabled");
    send_tx(8'h81, 2'b11, 1, 1, 0, 1, 0, 0, 0, "R9 recovery after break");
    // R7: overrun
    send_tx(8'h11, 2'b11, 1, 1, 0, 0, 0, 0, 1, "R7 lost while full");
    send_tx(8'h22, 2'b11, 1, 0, 0, 1, 0, 0, 0, "R7 overrun flagged");
    send_tx(8'h33, 2'b11, 1, 0, 0, 1, 0, 0, 0, "R7 overrun cleared");

    repeat (4 * OS) @(negedge clk);
    check("R5 all expected writes seen", 16'(exp_q.size()), 16'h0000);
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    finish_run();
  end

endmodule